// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block is a wall-time counter that keeps whole seconds in a 32-bit register and sits on a simple 32-bit register bus. A prescaler divides the block clock down to one tick per second. The divide ratio is a parameter. The counter moves by one on each tick while counting is switched on. Software sets the time through a staging register. The staged value is applied only on the next tick, so the seconds boundary always stays aligned with the prescaler.

An alarm register is compared against the counter on every tick. When the two become equal, a sticky raw flag is set. That flag reaches the interrupt pin only while the interrupt is enabled and not masked. Software acknowledges the alarm by reading a dedicated clear-on-read register. A fixed identification word and a raw view of the flag are also readable. When counting passes the all-ones value, the counter either rolls over to zero or holds, as software chooses.

Top module: `rtcsec_timer`

## Requirements
- R1: After reset the counter, alarm, staging and control registers read zero, and both the status and the irq output are low.
- R2: While the counter-enable bit (control bit 2) is set, the counter advances by exactly one every TICK_DIV clocks. The first step comes TICK_DIV clocks after the write that sets the bit. While the bit is clear, the counter holds its value.
- R3: A write to the staging register (offset 0x08) does not change the counter (offset 0x00) at once. The staged value is copied into the counter on the next tick, in place of the increment.
- R4: With the rollover bit (control bit 3) clear, a tick at 0xFFFFFFFF leaves the counter at 0xFFFFFFFF.
- R5: With the rollover bit set, a tick at 0xFFFFFFFF takes the counter to 0.
- R6: The raw flag (bit 0 at offset 0x14) is set on the tick that makes the counter equal to the alarm value (offset 0x04). It stays set while the counter moves on.
- R7: The status bit (bit 0 at offset 0x10) and the irq output both equal raw AND enable (control bit 0) AND NOT mask (control bit 1).
- R8: A read of offset 0x18 returns the raw flag in bit 0 and then clears it, which drops irq.
- R9: Bus writes to offsets 0x00, 0x10, 0x14, 0x18 and 0x1C change nothing that can be read back.
- R10: Offset 0x1C reads the VERSION parameter. Any offset with no register, including a misaligned one, reads zero.
- R11: The alarm, staging and control registers (control in bits 3:0) read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, divided down to the seconds tick |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access is addressed to this block |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_rd | input | 1 | Read strobe, qualified by bus_sel; side effects happen at the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume that a read strobe and a write strobe never share a cycle and that TICK_DIV is at least 2. With that ratio, two ticks can never fall in consecutive clocks. The bench drives exactly one strobe per access and runs with a divide of 8. It reads values through a side-effect-free peek that never raises bus_rd. Only the acknowledge read pulses bus_rd. All time-dependent checks count clocks from the edge that enabled counting, so every sample lands at a known prescaler phase.

// File: rtl/rtcsec_pkg.sv
// Shared constants and types for the seconds counter.
// Assumes byte offsets on a 32-bit word bus.
package rtcsec_pkg;
    localparam int OFF_COUNT   = 'h00;
    localparam int OFF_ALARM   = 'h04;
    localparam int OFF_STAGE   = 'h08;
    localparam int OFF_CTRL    = 'h0C;
    localparam int OFF_STATUS  = 'h10;
    localparam int OFF_RAW     = 'h14;
    localparam int OFF_ACK     = 'h18;
    localparam int OFF_VERSION = 'h1C;

    localparam int DATA_W = 32;
    localparam int CTRL_W = 4;

    // Packed MSB first: bit3 rollover, bit2 count enable, bit1 mask, bit0 irq enable
    typedef struct packed {
        logic roll;
        logic run;
        logic mask;
        logic ien;
    } ctrl_t;
endpackage

// File: rtl/rtcsec_prescaler.sv
// Divides clk into a single-cycle tick every DIV clocks while run is high.
// Assumes DIV >= 2. The phase restarts from zero whenever run is low.
module rtcsec_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Phase counter: runs 0..DIV-1 while enabled, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign tick = run && (phase_q == LAST);

    // R2
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    generate
        if (DIV >= 2) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/rtcsec_counter.sv
// Seconds counter with a staged load, rollover/hold at all-ones, and a sticky alarm-hit flag.
// Assumes tick is a single-cycle pulse. The staged value replaces the increment on the next tick.
module rtcsec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         roll,
    input  logic         stage_wr,
    input  logic [W-1:0] stage_data,
    input  logic [W-1:0] alarm,
    input  logic         ack,
    output logic [W-1:0] count,
    output logic [W-1:0] stage_val,
    output logic         raw
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] count_q, stage_q, count_nx;
    logic         pend_q, raw_q, hit;

    // Value that the counter takes on this tick
    always_comb begin
        if (pend_q)                      count_nx = stage_q;
        else if (count_q != ALL_ONES)    count_nx = count_q + 1'b1;
        else if (roll)                   count_nx = '0;
        else                             count_nx = count_q;
    end

    assign hit = tick && (count_nx == alarm);

    // Counter and staging register; a write in a tick cycle stays pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            stage_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (tick) begin
                count_q <= count_nx;
                pend_q  <= 1'b0;
            end
            if (stage_wr) begin
                stage_q <= stage_data;
                pend_q  <= 1'b1;
            end
        end
    end

    // Sticky alarm flag: set wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)   raw_q <= 1'b0;
        else if (hit) raw_q <= 1'b1;
        else if (ack) raw_q <= 1'b0;
    end

    assign count     = count_q;
    assign stage_val = stage_q;
    assign raw       = raw_q;

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));
    // R3
    staged_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_q) |=> (count_q == $past(stage_q)));
    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pend_q && !roll && count_q == ALL_ONES) |=> (count_q == ALL_ONES));
    // R6
    sticky_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q && !ack) |=> raw_q);
    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !raw_q);
endmodule

// File: rtl/rtcsec_regs.sv
// Register bus decode: control, alarm, staging strobe, acknowledge-on-read and the read mux.
// Assumes bus_rd and bus_wr are not both asserted in one cycle; rdata is combinational.
module rtcsec_regs
    import rtcsec_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       count,
    input  logic [31:0]       stage_val,
    input  logic              raw,
    output ctrl_t             ctrl,
    output logic [31:0]       alarm,
    output logic              stage_wr,
    output logic              ack,
    output logic              irq
);
    ctrl_t       ctrl_q;
    logic [31:0] alarm_q;
    logic        wr_en, rd_en, status;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && bus_rd;

    // Writable registers: control and alarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            alarm_q <= '0;
        end else if (wr_en) begin
            if (bus_addr == ADDR_W'(OFF_CTRL))  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (bus_addr == ADDR_W'(OFF_ALARM)) alarm_q <= bus_wdata;
        end
    end

    assign stage_wr = wr_en && (bus_addr == ADDR_W'(OFF_STAGE));
    assign ack      = rd_en && (bus_addr == ADDR_W'(OFF_ACK));
    assign status   = raw && ctrl_q.ien && !ctrl_q.mask;

    // Read mux, zero for unmapped offsets
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_COUNT):   bus_rdata = count;
            ADDR_W'(OFF_ALARM):   bus_rdata = alarm_q;
            ADDR_W'(OFF_STAGE):   bus_rdata = stage_val;
            ADDR_W'(OFF_CTRL):    bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
            ADDR_W'(OFF_STATUS):  bus_rdata = {31'b0, status};
            ADDR_W'(OFF_RAW):     bus_rdata = {31'b0, raw};
            ADDR_W'(OFF_ACK):     bus_rdata = {31'b0, raw};
            ADDR_W'(OFF_VERSION): bus_rdata = VERSION;
            default:              bus_rdata = '0;
        endcase
    end

    assign ctrl  = ctrl_q;
    assign alarm = alarm_q;
    assign irq   = status;

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && ctrl_q.ien && !ctrl_q.mask));
    // R11
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == ADDR_W'(OFF_CTRL)) |=> (ctrl_q == ctrl_t'($past(bus_wdata[CTRL_W-1:0]))));
endmodule

// File: rtl/rtcsec_timer.sv
// Top of the seconds counter: prescaler, counter core and register bus.
// Assumes TICK_DIV >= 2 and word-aligned byte offsets on bus_addr.
module rtcsec_timer
    import rtcsec_pkg::*;
#(
    parameter int          TICK_DIV = 32768,
    parameter int          ADDR_W   = 6,
    parameter logic [31:0] VERSION  = 32'h0001_0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    ctrl_t       ctrl;
    logic [31:0] alarm, count, stage_val;
    logic        tick, raw, stage_wr, ack;

    rtcsec_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .tick(tick)
    );

    rtcsec_counter #(.W(DATA_W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick(tick), .roll(ctrl.roll),
        .stage_wr(stage_wr), .stage_data(bus_wdata), .alarm(alarm), .ack(ack),
        .count(count), .stage_val(stage_val), .raw(raw)
    );

    rtcsec_regs #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .stage_val(stage_val), .raw(raw), .ctrl(ctrl),
        .alarm(alarm), .stage_wr(stage_wr), .ack(ack), .irq(irq)
    );

    // R2
    frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |=> $stable(count));
    // R7
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw);
endmodule

// File: tb/test_rtcsec_timer.sv
module test_rtcsec_timer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int AW         = 6;
    localparam logic [31:0] VER = 32'hA5C3_0107;

    localparam logic [AW-1:0] A_CNT = 6'h00, A_ALM = 6'h04, A_STG = 6'h08, A_CTL = 6'h0C,
                              A_STS = 6'h10, A_RAW = 6'h14, A_ACK = 6'h18, A_VER = 6'h1C;
    localparam logic [31:0] IEN = 32'h1, MSK = 32'h2, RUN = 32'h4, ROLL = 32'h8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;
    int checks = 0, fails = 0;
    logic done = 0;

    rtcsec_timer #(.TICK_DIV(DIV), .ADDR_W(AW), .VERSION(VER)) i_rtcsec_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic rd_ack(output logic [31:0] d);
        bus_sel = 1; bus_rd = 1; bus_addr = A_ACK;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v, c0;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
        // R1 reset state
        peek(A_CNT, v); check("R1 count", v, 0);
        peek(A_ALM, v); check("R1 alarm", v, 0);
        peek(A_STG, v); check("R1 stage", v, 0);
        peek(A_CTL, v); check("R1 ctrl", v, 0);
        peek(A_STS, v); check("R1 status", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R11 readback
        wr(A_ALM, 32'hFFFF_0000); peek(A_ALM, v); check("R11 alarm", v, 32'hFFFF_0000);
        wr(A_STG, 32'd100);       peek(A_STG, v); check("R11 stage", v, 100);
        // R3 staged value not visible yet
        peek(A_CNT, v); check("R3 not immediate", v, 0);
        wr(A_CTL, RUN);
        peek(A_CTL, v); check("R11 ctrl", v, RUN);
        wait_cyc(DIV-1); peek(A_CNT, v); check("R3 before tick", v, 0);
        wait_cyc(1);     peek(A_CNT, v); check("R3 on tick", v, 100);
        wait_cyc(DIV);   peek(A_CNT, v); check("R2 step", v, 101);
        for (int k = 1; k <= 5; k++) begin
            wait_cyc(DIV-1); peek(A_CNT, v); check("R2 mid-period", v, 101 + k - 1);
            wait_cyc(1);     peek(A_CNT, v); check("R2 sweep", v, 101 + k);
        end
        // R2 hold while stopped
        wr(A_CTL, 0);
        wait_cyc(3*DIV); peek(A_CNT, v); check("R2 stopped", v, 106);

        // R4 saturation
        wr(A_STG, 32'hFFFF_FFFE);
        wr(A_CTL, RUN);
        wait_cyc(DIV); peek(A_CNT, v); check("R4 load", v, 32'hFFFF_FFFE);
        wait_cyc(DIV); peek(A_CNT, v); check("R4 max", v, 32'hFFFF_FFFF);
        wait_cyc(DIV); peek(A_CNT, v); check("R4 hold", v, 32'hFFFF_FFFF);
        wait_cyc(DIV); peek(A_CNT, v); check("R4 hold2", v, 32'hFFFF_FFFF);
        // R5 rollover
        wr(A_CTL, 0);
        wr(A_CTL, RUN | ROLL);
        wait_cyc(DIV); peek(A_CNT, v); check("R5 wrap", v, 0);
        wait_cyc(DIV); peek(A_CNT, v); check("R5 after wrap", v, 1);

        // R6 alarm match
        wr(A_CTL, 0);
        wr(A_STG, 32'd10);
        wr(A_ALM, 32'd12);
        peek(A_RAW, v); check("R6 raw idle", v, 0);
        wr(A_CTL, RUN | IEN);
        wait_cyc(DIV); peek(A_CNT, v); check("R6 count10", v, 10);
        peek(A_RAW, v); check("R6 raw at 10", v, 0);
        check("R7 irq at 10", {31'b0, irq}, 0);
        wait_cyc(DIV); peek(A_RAW, v); check("R6 raw at 11", v, 0);
        wait_cyc(DIV); peek(A_CNT, v); check("R6 count12", v, 12);
        peek(A_RAW, v); check("R6 raw set", v, 1);
        peek(A_STS, v); check("R7 status set", v, 1);
        check("R7 irq set", {31'b0, irq}, 1);
        wait_cyc(DIV); peek(A_CNT, v); check("R6 count13", v, 13);
        peek(A_RAW, v); check("R6 sticky", v, 1);
        // R7 sweep over enable and mask
        for (int m = 0; m < 4; m++) begin
            logic e, k;
            e = m[0]; k = m[1];
            wr(A_CTL, RUN | (e ? IEN : 0) | (k ? MSK : 0));
            peek(A_STS, v); check("R7 status sweep", v, {31'b0, e & ~k});
            check("R7 irq sweep", {31'b0, irq}, {31'b0, e & ~k});
            peek(A_RAW, v); check("R7 raw unaffected", v, 1);
        end
        wr(A_CTL, RUN | IEN);
        // R8 acknowledge
        rd_ack(v); check("R8 ack read value", v, 1);
        peek(A_RAW, v); check("R8 raw cleared", v, 0);
        check("R8 irq cleared", {31'b0, irq}, 0);

        // R9 read-only writes ignored
        wr(A_CTL, 0);
        peek(A_CNT, c0);
        wr(A_CNT, 32'h0000_DEAD); peek(A_CNT, v); check("R9 count write", v, c0);
        wr(A_STS, 32'hFFFF_FFFF); peek(A_STS, v); check("R9 status write", v, 0);
        wr(A_RAW, 32'hFFFF_FFFF); peek(A_RAW, v); check("R9 raw write", v, 0);
        wr(A_ACK, 32'hFFFF_FFFF); peek(A_RAW, v); check("R9 ack write", v, 0);
        wr(A_VER, 32'h1234_5678); peek(A_VER, v); check("R9 version write", v, VER);
        peek(A_CNT, v); check("R9 count after writes", v, c0);

        // R10 version and unmapped offsets
        peek(A_VER, v); check("R10 version", v, VER);
        for (int a = 32; a < 64; a += 4) begin
            peek(AW'(a), v); check("R10 unmapped", v, 0);
        end
        peek(6'h02, v); check("R10 misaligned", v, 0);

        done = 1;
        summary();
    end
endmodule